// File: doc/BRIEF.md
# Power Supply Management Register Slave

This block is an I2C target that sits on a management bus at an address picked by three board strap pins. A host reaches 16-bit registers through an 8-bit register number. A read runs in this order: the address with the write bit, the register number, a repeated START, the address with the read bit, and then two data bytes. The low byte of the word goes out first. Status, fault and sensor words are assembled from a 27-byte status bank that the rest of the supply keeps up to date. A few fixed identification words come from parameters, and every other register number reads as zero.

A write that carries only a register number acts as a one-byte command. Three command values switch the output off, switch it on, and request that the alert line be released. The output-enable state can also be changed by an active-low enable pin. Only level changes on that pin count, and whichever event came last, pin or command, sets the state. Commands and word writes take effect at STOP. After that the block refuses its own address for a fixed number of clock cycles while the internal update runs.

SCL and SDA are sampled on the system clock through a synchroniser. The block drives SDA through an open-drain enable and never holds SCL.

Top module: `pmr_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address formed as binary 1011 followed by the three strap bits (strap bit 2 is the most significant). No other address gets an acknowledge.
- R2: In a read, the byte after the acknowledged read address is bits 7:0 of the selected word and the next byte is bits 15:8. Each byte is sent MSB first.
- R3: After the high byte, every further byte read in the same transfer is 0xFF, because the block leaves SDA released.
- R4: Register 0xD0 returns bank byte 1 low and bank byte 0 high. Register 0xD1 returns byte 3 low and byte 2 high. Register 0xD2 returns byte 26 low and 0x00 high.
- R5: Sensor words return the even bank byte as the high byte and the next odd byte as the low byte. The mapping from register to even byte is: 0x28→4, 0x33→6, 0x29→8, 0x34→10, 0x20→12, 0x21→14, 0x02→16, 0x01→18, 0x32→20, 0x3D→22, 0x00→24.
- R6: Registers 0x3E, 0x3F and 0x40 return their constant parameters (0x5053, 0x4D49 and 0x020C by default). Every other register number returns 0x0000.
- R7: A write transfer holding exactly one byte ends at STOP. If that byte is 0xD4 the output is enabled, and if it is 0xD3 the output is disabled.
- R8: A single-byte write of 0xD5 produces a pulse on the alert-clear output that lasts exactly one clock cycle, and it leaves the output enable unchanged.
- R9: A high-to-low change on the active-low enable pin enables the output, and a low-to-high change disables it. A steady pin level never overrides a later command. If a pin change and a command fall in the same cycle, the command wins.
- R10: For BUSY_CYC clock cycles after the STOP of a write transfer, the block does not acknowledge its own address.
- R11: A write with one or more data bytes after the register number has every byte acknowledged. It changes no register contents and issues no command.
- R12: After reset the output enable is off, SDA is released and the alert-clear output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pulls SDA low |
| slot_id | input | 3 | Address strap pins |
| stat_bank | input | 8*STAT_BYTES | Status bank; byte i sits at bits 8i+7:8i |
| pson_n | input | 1 | Active-low output enable pin |
| out_en | output | 1 | Output enable state |
| alert_clr | output | 1 | One-cycle request to release the alert line |

## Verification
The bench builds the block with BUSY_CYC set to 600, two synchroniser stages and a strap value of 5. The short lockout lets the bench probe the address once right after a write's STOP and see it refused, then probe it again after the window and see it acknowledged, all inside one run. The default constant parameters are kept, so the identification words can be compared against their fixed values. A bus quarter-period of eight clocks leaves room for the synchroniser latency before each SCL edge.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   typedef enum logic [2:0] {
      LK_IDLE, LK_ADDR, LK_ACK, LK_RX, LK_TX, LK_TXACK
   } link_st_t;

   localparam logic [3:0] ADDR_PREFIX = 4'b1011;
   localparam logic [7:0] CMD_OUT_OFF = 8'hD3;
   localparam logic [7:0] CMD_OUT_ON  = 8'hD4;
   localparam logic [7:0] CMD_ALERT   = 8'hD5;
endpackage

// File: rtl/pmr_sync.sv
module pmr_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rose,
   output logic [W-1:0] fell
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;
   logic [W-1:0]             prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= {STAGES{RST_VAL}};
         prev <= RST_VAL;
      end else begin
         stg  <= {stg[STAGES-2:0], d};
         prev <= stg[STAGES-1];
      end
   end

   assign q    = stg[STAGES-1];
   assign rose = q & ~prev;
   assign fell = ~q & prev;
endmodule

// File: rtl/pmr_link.sv
module pmr_link import pmr_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       scl_rose,
   input  logic       scl_fell,
   input  logic       sda_s,
   input  logic       sda_rose,
   input  logic       sda_fell,
   input  logic [6:0] dev_addr,
   input  logic       busy,
   input  logic [7:0] tx_data,
   output logic       sda_oe,
   output logic       addr_hit,
   output logic       addr_rd,
   output logic       rx_stb,
   output logic [7:0] rx_byte,
   output logic       tx_req,
   output logic       stop_stb
);
   link_st_t   st_q;
   logic [7:0] sh_q, tx_q;
   logic [3:0] bit_q;
   logic       rd_q, nack_q;

   wire start_c = scl_s & sda_fell;
   wire stop_c  = scl_s & sda_rose;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= LK_IDLE; sh_q <= '0; tx_q <= '0; bit_q <= '0;
         rd_q <= 1'b0; nack_q <= 1'b1; sda_oe <= 1'b0;
         addr_hit <= 1'b0; rx_stb <= 1'b0; tx_req <= 1'b0; stop_stb <= 1'b0;
      end else begin
         addr_hit <= 1'b0; rx_stb <= 1'b0; tx_req <= 1'b0; stop_stb <= 1'b0;
         if (stop_c) begin
            st_q <= LK_IDLE; sda_oe <= 1'b0; stop_stb <= 1'b1;
         end else if (start_c) begin
            st_q <= LK_ADDR; bit_q <= '0; sda_oe <= 1'b0;
         end else if (scl_rose) begin
            case (st_q)
               LK_ADDR, LK_RX: begin sh_q <= {sh_q[6:0], sda_s}; bit_q <= bit_q + 4'd1; end
               LK_TX:          bit_q  <= bit_q + 4'd1;
               LK_TXACK:       nack_q <= sda_s;
               default: ;
            endcase
         end else if (scl_fell) begin
            case (st_q)
               LK_ADDR: if (bit_q == 4'd8) begin
                  if (sh_q[7:1] == dev_addr && !busy) begin
                     sda_oe <= 1'b1; rd_q <= sh_q[0]; addr_hit <= 1'b1; st_q <= LK_ACK;
                  end else begin
                     st_q <= LK_IDLE;
                  end
               end
               LK_RX: if (bit_q == 4'd8) begin
                  rx_stb <= 1'b1; sda_oe <= 1'b1; st_q <= LK_ACK;
               end
               LK_ACK: begin
                  bit_q <= '0;
                  if (rd_q) begin
                     tx_q <= tx_data; tx_req <= 1'b1; sda_oe <= ~tx_data[7]; st_q <= LK_TX;
                  end else begin
                     sda_oe <= 1'b0; st_q <= LK_RX;
                  end
               end
               LK_TX: begin
                  if (bit_q == 4'd8) begin sda_oe <= 1'b0; st_q <= LK_TXACK; end
                  else sda_oe <= ~tx_q[3'd7 - bit_q[2:0]];
               end
               LK_TXACK: begin
                  if (!nack_q) begin
                     bit_q <= '0; tx_q <= tx_data; tx_req <= 1'b1;
                     sda_oe <= ~tx_data[7]; st_q <= LK_TX;
                  end else begin
                     st_q <= LK_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign addr_rd = rd_q;
   assign rx_byte = sh_q;

   // SDA is only pulled low while the synchronised SCL is low (R1, R2)
   assert_sda_pull_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);
   // a received byte strobe always comes with SDA held for the acknowledge (R11)
   assert_rx_acked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |-> sda_oe);
endmodule

// File: rtl/pmr_regs.sv
module pmr_regs import pmr_pkg::*; #(
   parameter int          STAT_BYTES = 27,
   parameter int          BUSY_CYC   = 4000,
   parameter logic [15:0] ID_WORD0   = 16'h5053,
   parameter logic [15:0] ID_WORD1   = 16'h4D49,
   parameter logic [15:0] VER_WORD   = 16'h020C,
   parameter logic        EN_RST     = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [8*STAT_BYTES-1:0] bank,
   input  logic                    addr_hit,
   input  logic                    addr_rd,
   input  logic                    rx_stb,
   input  logic [7:0]              rx_byte,
   input  logic                    tx_req,
   input  logic                    stop_stb,
   input  logic                    pin_rose,
   input  logic                    pin_fell,
   output logic [7:0]              tx_data,
   output logic                    busy,
   output logic                    out_en,
   output logic                    alert_clr
);
   localparam int BW = $clog2(BUSY_CYC + 1);

   if (STAT_BYTES < 27) begin : g_bad_bank
      $error("pmr_regs: status bank needs at least 27 bytes");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("pmr_regs: BUSY_CYC must be positive");
   end

   logic [7:0] bk [STAT_BYTES];
   for (genvar g = 0; g < STAT_BYTES; g++) begin : g_bank
      assign bk[g] = bank[8*g +: 8];
   end

   logic [7:0]    ptr_q;
   logic [1:0]    wr_cnt, rd_idx;
   logic          in_wr;
   logic [BW-1:0] busy_cnt;
   logic [15:0]   word;

   always_comb begin
      case (ptr_q)
         8'hD0:   word = {bk[0],  bk[1]};
         8'hD1:   word = {bk[2],  bk[3]};
         8'hD2:   word = {8'h00,  bk[26]};
         8'h28:   word = {bk[4],  bk[5]};
         8'h33:   word = {bk[6],  bk[7]};
         8'h29:   word = {bk[8],  bk[9]};
         8'h34:   word = {bk[10], bk[11]};
         8'h20:   word = {bk[12], bk[13]};
         8'h21:   word = {bk[14], bk[15]};
         8'h02:   word = {bk[16], bk[17]};
         8'h01:   word = {bk[18], bk[19]};
         8'h32:   word = {bk[20], bk[21]};
         8'h3D:   word = {bk[22], bk[23]};
         8'h00:   word = {bk[24], bk[25]};
         8'h3E:   word = ID_WORD0;
         8'h3F:   word = ID_WORD1;
         8'h40:   word = VER_WORD;
         default: word = 16'h0000;
      endcase
      case (rd_idx)
         2'd0:    tx_data = word[7:0];
         2'd1:    tx_data = word[15:8];
         default: tx_data = 8'hFF;
      endcase
   end

   wire cmd_done  = stop_stb && in_wr && wr_cnt == 2'd1;
   wire cmd_on    = cmd_done && ptr_q == CMD_OUT_ON;
   wire cmd_off   = cmd_done && ptr_q == CMD_OUT_OFF;
   wire cmd_alert = cmd_done && ptr_q == CMD_ALERT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0; wr_cnt <= '0; rd_idx <= '0; in_wr <= 1'b0;
         busy_cnt <= '0; out_en <= EN_RST; alert_clr <= 1'b0;
      end else begin
         alert_clr <= cmd_alert;
         if (addr_hit) begin
            in_wr  <= !addr_rd;
            wr_cnt <= '0;
            rd_idx <= '0;
         end
         if (rx_stb) begin
            if (wr_cnt == 2'd0) ptr_q <= rx_byte;
            if (wr_cnt != 2'd2) wr_cnt <= wr_cnt + 2'd1;
         end
         if (tx_req && rd_idx != 2'd2) rd_idx <= rd_idx + 2'd1;
         if (stop_stb) begin
            in_wr <= 1'b0;
            if (in_wr && wr_cnt != 2'd0) busy_cnt <= BW'(BUSY_CYC);
         end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
         end
         // pin edges first, a command in the same cycle overrides them
         if (pin_fell)      out_en <= 1'b1;
         else if (pin_rose) out_en <= 1'b0;
         if (cmd_on)        out_en <= 1'b1;
         else if (cmd_off)  out_en <= 1'b0;
      end
   end

   assign busy = busy_cnt != '0;

   assert_cmd_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_on |=> out_en);
   assert_cmd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_off |=> !out_en);
   assert_pin_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_fell && !cmd_off) |=> out_en);
   assert_pin_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_rose && !cmd_on) |=> !out_en);
   assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_fell && !pin_rose && !stop_stb) |=> $stable(out_en));
   assert_alert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alert_clr |=> !alert_clr);
   assert_no_ack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hit |-> !busy);
endmodule

// File: rtl/pmr_slave.sv
module pmr_slave import pmr_pkg::*; #(
   parameter int          STAT_BYTES  = 27,
   parameter int          BUSY_CYC    = 4000,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] ID_WORD0    = 16'h5053,
   parameter logic [15:0] ID_WORD1    = 16'h4D49,
   parameter logic [15:0] VER_WORD    = 16'h020C,
   parameter logic        EN_RST      = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   input  logic [2:0]              slot_id,
   input  logic [8*STAT_BYTES-1:0] stat_bank,
   input  logic                    pson_n,
   output logic                    out_en,
   output logic                    alert_clr
);
   logic [2:0] s_q, s_rose, s_fell;
   logic       addr_hit, addr_rd, rx_stb, tx_req, stop_stb, busy;
   logic [7:0] rx_byte, tx_data;

   pmr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({pson_n, sda_i, scl_i}),
      .q(s_q), .rose(s_rose), .fell(s_fell));

   pmr_link u_link (
      .clk(clk), .rst_n(rst_n),
      .scl_s(s_q[0]), .scl_rose(s_rose[0]), .scl_fell(s_fell[0]),
      .sda_s(s_q[1]), .sda_rose(s_rose[1]), .sda_fell(s_fell[1]),
      .dev_addr({ADDR_PREFIX, slot_id}), .busy(busy), .tx_data(tx_data),
      .sda_oe(sda_oe), .addr_hit(addr_hit), .addr_rd(addr_rd),
      .rx_stb(rx_stb), .rx_byte(rx_byte), .tx_req(tx_req), .stop_stb(stop_stb));

   pmr_regs #(.STAT_BYTES(STAT_BYTES), .BUSY_CYC(BUSY_CYC), .ID_WORD0(ID_WORD0),
              .ID_WORD1(ID_WORD1), .VER_WORD(VER_WORD), .EN_RST(EN_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .bank(stat_bank),
      .addr_hit(addr_hit), .addr_rd(addr_rd), .rx_stb(rx_stb), .rx_byte(rx_byte),
      .tx_req(tx_req), .stop_stb(stop_stb),
      .pin_rose(s_rose[2]), .pin_fell(s_fell[2]),
      .tx_data(tx_data), .busy(busy), .out_en(out_en), .alert_clr(alert_clr));
endmodule

// File: tb/tb_pmr_slave.sv
`timescale 1ns/1ps
module tb_pmr_slave;
   localparam int BUSY = 600;
   localparam int Q    = 8;
   localparam int NB   = 27;
   localparam logic [2:0] SLOT = 3'd5;
   localparam logic [7:0] AW = {4'b1011, SLOT, 1'b0};
   localparam logic [7:0] AR = {4'b1011, SLOT, 1'b1};

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0, pson_n = 1'b1;
   logic [2:0] slot_id = SLOT;
   logic [8*NB-1:0] stat_bank;
   logic sda_oe, out_en, alert_clr;
   wire  scl_line = !m_scl_low;
   wire  sda_line = !(m_sda_low || sda_oe);

   always #4 clk = ~clk;

   pmr_slave #(.STAT_BYTES(NB), .BUSY_CYC(BUSY), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
      .slot_id(slot_id), .stat_bank(stat_bank), .pson_n(pson_n),
      .out_en(out_en), .alert_clr(alert_clr));

   int n_chk = 0, n_bad = 0, alert_cyc = 0;
   logic [7:0] exp_q[$], got_q[$];
   string      tag_q[$];

   function automatic logic [7:0] bkv(int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
   endtask

   always @(posedge clk) if (alert_clr) alert_cyc++;

   // monitor: compare each byte the design returns with the next expected one
   initial forever begin
      wait (got_q.size() != 0);
      chk(got_q[0] == exp_q[0], tag_q[0], got_q[0], exp_q[0]);
      void'(got_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
   end

   task automatic tick(int n); repeat (n) @(negedge clk); endtask
   task automatic bit_out(logic b);
      m_sda_low = !b; tick(Q); m_scl_low = 1'b0; tick(2*Q); m_scl_low = 1'b1; tick(Q);
   endtask
   task automatic bit_in(output logic b);
      m_sda_low = 1'b0; tick(Q); m_scl_low = 1'b0; tick(Q); b = sda_line; tick(Q);
      m_scl_low = 1'b1; tick(Q);
   endtask
   task automatic i2c_start();
      m_sda_low = 1'b1; tick(2*Q); m_scl_low = 1'b1; tick(Q);
   endtask
   task automatic i2c_rstart();
      m_sda_low = 1'b0; tick(Q); m_scl_low = 1'b0; tick(Q); m_sda_low = 1'b1; tick(Q);
      m_scl_low = 1'b1; tick(Q);
   endtask
   task automatic i2c_stop();
      m_sda_low = 1'b1; tick(Q); m_scl_low = 1'b0; tick(Q); m_sda_low = 1'b0; tick(2*Q);
   endtask
   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(s); ack = !s;
   endtask
   task automatic rd_byte(input logic m_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) bit_in(b[i]);
      bit_out(!m_ack);
   endtask

   task automatic rd_reg(input logic [7:0] r, input logic [15:0] w, input string t);
      logic a; logic [7:0] b;
      i2c_start(); wr_byte(AW, a); chk(a, {t, " address ack"}, a, 1);
      wr_byte(r, a); i2c_rstart(); wr_byte(AR, a);
      exp_q.push_back(w[7:0]);  tag_q.push_back({t, " R2 low byte"});
      exp_q.push_back(w[15:8]); tag_q.push_back({t, " R2 high byte"});
      rd_byte(1'b1, b); got_q.push_back(b);
      rd_byte(1'b0, b); got_q.push_back(b);
      i2c_stop();
   endtask

   task automatic cmd(input logic [7:0] c);
      logic a;
      i2c_start(); wr_byte(AW, a); wr_byte(c, a); i2c_stop();
   endtask

   function automatic logic [15:0] sw(int hi); return {bkv(hi), bkv(hi + 1)}; endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic a; logic [7:0] b; int ac0;
      for (int i = 0; i < NB; i++) stat_bank[8*i +: 8] = bkv(i);
      m_scl_low = 1'b0; m_sda_low = 1'b0;
      tick(5); rst_n = 1'b1; tick(5);
      chk(out_en == 1'b0, "R12 out_en after reset", out_en, 0);
      chk(sda_oe == 1'b0, "R12 sda released after reset", sda_oe, 0);
      chk(alert_clr == 1'b0, "R12 alert_clr after reset", alert_clr, 0);

      i2c_start(); wr_byte(8'hB0, a); chk(!a, "R1 foreign slot 0 nack", a, 0); i2c_stop();
      i2c_start(); wr_byte(8'hBC, a); chk(!a, "R1 foreign slot 6 nack", a, 0); i2c_stop();
      i2c_start(); wr_byte(8'hE0, a); chk(!a, "R1 other prefix nack", a, 0); i2c_stop();
      i2c_start(); wr_byte(AW, a);    chk(a, "R1 own address ack", a, 1); i2c_stop();

      rd_reg(8'hD0, {bkv(0), bkv(1)},  "R4 reg D0");
      rd_reg(8'hD1, {bkv(2), bkv(3)},  "R4 reg D1");
      rd_reg(8'hD2, {8'h00, bkv(26)},  "R4 reg D2");
      rd_reg(8'h28, sw(4),  "R5 reg 28"); rd_reg(8'h33, sw(6),  "R5 reg 33");
      rd_reg(8'h29, sw(8),  "R5 reg 29"); rd_reg(8'h34, sw(10), "R5 reg 34");
      rd_reg(8'h20, sw(12), "R5 reg 20"); rd_reg(8'h21, sw(14), "R5 reg 21");
      rd_reg(8'h02, sw(16), "R5 reg 02"); rd_reg(8'h01, sw(18), "R5 reg 01");
      rd_reg(8'h32, sw(20), "R5 reg 32"); rd_reg(8'h3D, sw(22), "R5 reg 3D");
      rd_reg(8'h00, sw(24), "R5 reg 00");
      rd_reg(8'h3E, 16'h5053, "R6 reg 3E"); rd_reg(8'h3F, 16'h4D49, "R6 reg 3F");
      rd_reg(8'h40, 16'h020C, "R6 reg 40"); rd_reg(8'h55, 16'h0000, "R6 unmapped 55");

      // R3: a third byte after the high byte
      i2c_start(); wr_byte(AW, a); wr_byte(8'h3E, a); i2c_rstart(); wr_byte(AR, a);
      rd_byte(1'b1, b); rd_byte(1'b1, b); rd_byte(1'b0, b);
      chk(b == 8'hFF, "R3 byte after high byte", b, 8'hFF); i2c_stop();

      cmd(8'hD4); chk(out_en == 1'b1, "R7 enable command", out_en, 1); tick(BUSY + 20);
      cmd(8'hD3); chk(out_en == 1'b0, "R7 disable command", out_en, 0); tick(BUSY + 20);

      pson_n = 1'b0; tick(10); chk(out_en == 1'b1, "R9 pin falling enables", out_en, 1);
      cmd(8'hD3); tick(BUSY + 20);
      chk(out_en == 1'b0, "R9 command after pin low wins", out_en, 0);
      pson_n = 1'b1; tick(10); chk(out_en == 1'b0, "R9 pin rise keeps off", out_en, 0);
      cmd(8'hD4); tick(BUSY + 20);
      pson_n = 1'b0; tick(10); chk(out_en == 1'b1, "R9 pin fall while on", out_en, 1);
      pson_n = 1'b1; tick(10); chk(out_en == 1'b0, "R9 pin rising disables", out_en, 0);

      ac0 = alert_cyc; cmd(8'hD5); tick(20);
      chk(alert_cyc - ac0 == 1, "R8 alert pulse width", alert_cyc - ac0, 1);
      chk(out_en == 1'b0, "R8 alert leaves enable", out_en, 0);
      tick(BUSY + 20);

      // R11 word write to the enable command number and to a constant register
      i2c_start(); wr_byte(AW, a); wr_byte(8'hD4, a);
      wr_byte(8'h01, a); chk(a, "R11 data low ack", a, 1);
      wr_byte(8'h02, a); chk(a, "R11 data high ack", a, 1); i2c_stop(); tick(10);
      chk(out_en == 1'b0, "R11 word write issues no command", out_en, 0);
      tick(BUSY + 20);
      i2c_start(); wr_byte(AW, a); wr_byte(8'h3E, a); wr_byte(8'h12, a); wr_byte(8'h34, a);
      i2c_stop();
      i2c_start(); wr_byte(AW, a); chk(!a, "R10 address refused while busy", a, 0); i2c_stop();
      tick(BUSY + 20);
      rd_reg(8'h3E, 16'h5053, "R11 R10 constant kept after write");

      wait (got_q.size() == 0); tick(5);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule